// File: doc/BRIEF.md
# Serial Clock Wait-Insertion Controller

This block sits beside a synchronous serial shifter and decides when to stretch the serial clock. It follows the bus clock and data lines and counts the falling clock edges of each byte. In 2-wire bus mode it also recognises a start condition. When the count reaches the point chosen by software, it pulls the clock line low through an open-drain enable and raises a wait flag. The wait lasts until software writes a release.

Software controls the block through one 4-bit register write. Bits [1:0] hold the wait-request code. Bit 2 is the hold bit: writing 1 forces a wait and writing 0 releases it. Bit 3 is the acknowledge bit: writing 1 makes the block pull the data line low during the acknowledge clock. Every write updates all four bits at once.

Both lines pass through a two-flop synchronizer and then one edge-detect stage. As a result, a change on `scl_in` or `sda_in` shows up at the outputs at the third rising edge of `clk` after the change. A write takes effect at the rising edge that samples it.

Top module: `sclk_wait_ctrl`

## Requirements
- R1: After reset, `scl_hold`, `wait_active` and `ack_drive` are all 0.
- R2: With wait-request code 00, no clock edge ever starts a wait, in either mode.
- R3: In bus mode (`bus_mode`=1) with code 01, a wait starts on every falling edge that brings the bit count to 8. This is the 8th falling edge of each byte.
- R4: In bus mode with code 10, a wait starts on the falling edge that brings the bit count to 9.
- R5: In bus mode with code 11, a wait starts at count 8 only in the first byte after a start condition. In later bytes it does not.
- R6: In serial I/O mode (`bus_mode`=0), codes 01 and 10 start a wait at count 9 and code 11 starts none. A one-cycle `xfer_start` pulse clears the count in this mode.
- R7: A write with bit 2 set to 1 turns the wait on, and a write with bit 2 set to 0 turns it off, from the next cycle. Between writes, a wait stays on. `scl_hold` and `wait_active` always move together.
- R8: `ack_drive` is 1 only in bus mode, only while the count is 8 (between the 8th and 9th falling edges), and only when bit 3 of the last write is 1.
- R9: A start condition is the data line falling while the clock line is high. It clears the count in bus mode only. The count rises by one on each falling edge, and after 9 the next edge gives 1.
- R10: If a write and a wait trigger fall in the same cycle, the write decides the wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode | input | 1 | 1 = 2-wire bus mode, 0 = serial I/O mode |
| xfer_start | input | 1 | Transfer start pulse, used in serial I/O mode |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | [1:0] wait code, [2] hold, [3] acknowledge |
| scl_in | input | 1 | Serial clock line as seen on the pin |
| sda_in | input | 1 | Serial data line as seen on the pin |
| scl_hold | output | 1 | Open-drain enable that pulls the clock line low |
| ack_drive | output | 1 | Open-drain enable that pulls the data line low for acknowledge |
| wait_active | output | 1 | Wait status flag |

## Verification
A release write can land in the same system-clock cycle as the falling edge that reaches the programmed count. In that case the release and the trigger compete for the wait register. The bench provokes this by lowering `scl_in` and placing the write strobe on exactly the third rising edge after the change, which is the edge where the synchronized fall is seen. It then expects `wait_active` and `scl_hold` to stay low, because the write takes precedence.

// File: rtl/sclk_wait_ctrl.sv
module sclk_wait_ctrl #(
  parameter int BYTE_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_mode,
  input  logic       xfer_start,
  input  logic       ctrl_wr,
  input  logic [3:0] ctrl_wdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_hold,
  output logic       ack_drive,
  output logic       wait_active
);
  localparam int CNT_W = $clog2(BYTE_BITS + 2);
  localparam logic [CNT_W-1:0] ACK_CNT  = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_BITS + 1);

  logic [SYNC_STAGES:0] scl_sr, sda_sr;
  logic [1:0]       code_q;
  logic             ack_q, wait_q, first_q, match;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-1:0], scl_in};
      sda_sr <= {sda_sr[SYNC_STAGES-1:0], sda_in};
    end

  wire scl_now   = scl_sr[SYNC_STAGES-1];
  wire scl_prev  = scl_sr[SYNC_STAGES];
  wire fall      = scl_prev & ~scl_now;
  wire start_det = bus_mode & scl_now & scl_prev & sda_sr[SYNC_STAGES] & ~sda_sr[SYNC_STAGES-1];
  wire restart   = start_det | (~bus_mode & xfer_start);
  wire wrap      = fall & (cnt_q == LAST_CNT);

  always_comb begin
    if (restart)   cnt_nxt = '0;
    else if (wrap) cnt_nxt = CNT_W'(1);
    else if (fall) cnt_nxt = cnt_q + CNT_W'(1);
    else           cnt_nxt = cnt_q;
  end

  always_comb begin
    case (code_q)
      2'b01:   match = bus_mode ? (cnt_nxt == ACK_CNT) : (cnt_nxt == LAST_CNT);
      2'b10:   match = cnt_nxt == LAST_CNT;
      2'b11:   match = bus_mode & first_q & (cnt_nxt == ACK_CNT);
      default: match = 1'b0;
    endcase
  end

  wire trig = fall & ~restart & match;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
      code_q  <= 2'b00;
      ack_q   <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (start_det)  first_q <= 1'b1;
      else if (wrap)  first_q <= 1'b0;
      if (ctrl_wr) begin
        code_q <= ctrl_wdata[1:0];
        ack_q  <= ctrl_wdata[3];
        wait_q <= ctrl_wdata[2];
      end else if (trig) begin
        wait_q <= 1'b1;
      end
    end

  assign scl_hold    = wait_q;
  assign wait_active = wait_q;
  assign ack_drive   = bus_mode & ack_q & (cnt_q == ACK_CNT);
endmodule

// File: rtl/sclk_wait_ctrl_chk.sv
module sclk_wait_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_mode,
  input logic       ctrl_wr,
  input logic [3:0] ctrl_wdata,
  input logic       scl_hold,
  input logic       ack_drive,
  input logic       wait_active
);
  logic [1:0] code_s;
  logic       ack_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      code_s <= 2'b00;
      ack_s  <= 1'b0;
    end else if (ctrl_wr) begin
      code_s <= ctrl_wdata[1:0];
      ack_s  <= ctrl_wdata[3];
    end

  p_force_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && ctrl_wdata[2] |=> wait_active && scl_hold);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !ctrl_wdata[2] |=> !wait_active && !scl_hold);

  p_hold_persist_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_active && !ctrl_wr |=> wait_active);

  p_code0_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr && !wait_active && code_s == 2'b00 |=> !wait_active);

  p_sio_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr && !wait_active && code_s == 2'b11 && !bus_mode |=> !wait_active);

  p_ack_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drive |-> bus_mode && ack_s);
endmodule

bind sclk_wait_ctrl sclk_wait_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .ctrl_wr(ctrl_wr),
  .ctrl_wdata(ctrl_wdata), .scl_hold(scl_hold), .ack_drive(ack_drive),
  .wait_active(wait_active)
);

// File: tb/sclk_wait_ctrl_tb.sv
module sclk_wait_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_mode = 1'b1, xfer_start = 1'b0, ctrl_wr = 1'b0;
  logic [3:0] ctrl_wdata = 4'h0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic scl_hold, ack_drive, wait_active;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sclk_wait_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .xfer_start(xfer_start),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .scl_in(scl_in), .sda_in(sda_in),
    .scl_hold(scl_hold), .ack_drive(ack_drive), .wait_active(wait_active)
  );

  // {mode, code[1:0], wait after 8th fall, wait after 9th fall}
  localparam logic [4:0] VEC [8] = '{
    5'b1_00_0_0, 5'b1_01_1_0, 5'b1_10_0_1, 5'b1_11_1_0,
    5'b0_00_0_0, 5'b0_01_0_1, 5'b0_10_0_1, 5'b0_11_0_0
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_wait(input string req, input logic exp);
    chk(req, wait_active, exp);
    chk(req, scl_hold, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] d);
    ctrl_wdata = d;
    ctrl_wr = 1'b1;
    step(1);
    ctrl_wr = 1'b0;
  endtask

  task automatic fall_e;
    scl_in = 1'b0;
    step(4);
  endtask

  task automatic rise_e;
    scl_in = 1'b1;
    step(4);
  endtask

  task automatic start_cond;
    scl_in = 1'b1; sda_in = 1'b1; step(4);
    sda_in = 1'b0; step(4);
  endtask

  task automatic xfer;
    xfer_start = 1'b1;
    step(1);
    xfer_start = 1'b0;
  endtask

  task automatic clocks(input int n);
    for (int k = 0; k < n; k++) begin
      fall_e;
      rise_e;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    chk_wait("R1", 1'b0);
    chk("R1", ack_drive, 1'b0);

    for (int i = 0; i < 8; i++) begin
      bus_mode = VEC[i][4];
      wr({2'b00, VEC[i][3:2]});
      if (bus_mode) start_cond; else xfer;
      clocks(7);
      fall_e;
      chk_wait(VEC[i][4] ? "R3/R4/R5/R2 bus count8" : "R6/R2 sio count8", VEC[i][1]);
      if (wait_active) wr({2'b00, VEC[i][3:2]});
      rise_e;
      fall_e;
      chk_wait(VEC[i][4] ? "R3/R4/R5/R2 bus count9" : "R6/R2 sio count9", VEC[i][0]);
      if (wait_active) wr({2'b00, VEC[i][3:2]});
      rise_e;
    end

    // R7 force and release
    wr(4'b0100); chk_wait("R7 force", 1'b1);
    step(5);     chk_wait("R7 hold", 1'b1);
    wr(4'b0000); chk_wait("R7 release", 1'b0);

    // R3 and R9: wrap, second byte waits again at count 8
    bus_mode = 1'b1;
    wr(4'b0001); start_cond;
    clocks(7); fall_e; chk_wait("R3 byte1", 1'b1);
    wr(4'b0001); rise_e;
    fall_e; chk_wait("R9 count9 no wait", 1'b0); rise_e;
    clocks(6); fall_e; chk_wait("R9 wrap count7", 1'b0); rise_e;
    fall_e; chk_wait("R3 R9 byte2 count8", 1'b1);
    wr(4'b0001); rise_e;

    // R5: code 11 in second byte
    wr(4'b0011); start_cond;
    clocks(7); fall_e; chk_wait("R5 byte1", 1'b1);
    wr(4'b0011); rise_e;
    clocks(8); fall_e; chk_wait("R5 byte2 no wait", 1'b0); rise_e;

    // R9: second start mid-byte restarts count
    wr(4'b0001); start_cond;
    clocks(4);
    start_cond;
    clocks(7); chk_wait("R9 restart count7", 1'b0);
    fall_e; chk_wait("R9 restart count8", 1'b1);
    wr(4'b0000); rise_e;

    // R9: start condition ignored in serial I/O mode
    bus_mode = 1'b0;
    wr(4'b0001); xfer;
    clocks(4);
    start_cond;
    clocks(4); chk_wait("R9 sio start ignored count8", 1'b0);
    fall_e; chk_wait("R6 R9 sio count9", 1'b1);
    wr(4'b0000); rise_e;

    // R8 acknowledge drive
    bus_mode = 1'b1;
    wr(4'b1000); start_cond;
    clocks(6); fall_e; chk("R8 count7", ack_drive, 1'b0); rise_e;
    fall_e; chk("R8 count8", ack_drive, 1'b1); rise_e;
    chk("R8 count8 high", ack_drive, 1'b1);
    fall_e; chk("R8 count9", ack_drive, 1'b0); rise_e;
    wr(4'b0000); start_cond;
    clocks(7); fall_e; chk("R8 ack bit clear", ack_drive, 1'b0); rise_e;
    bus_mode = 1'b0;
    wr(4'b1000); xfer;
    clocks(7); fall_e; chk("R8 sio no ack", ack_drive, 1'b0); rise_e;

    // R10 release write in the trigger cycle
    bus_mode = 1'b1;
    wr(4'b0001); start_cond;
    clocks(7);
    scl_in = 1'b0;
    step(2);
    ctrl_wdata = 4'b0001;
    ctrl_wr = 1'b1;
    step(1);
    ctrl_wr = 1'b0;
    step(2);
    chk_wait("R10 write wins", 1'b0);
    rise_e;

    // R1 reset clears an active wait
    wr(4'b1100);
    rst_n = 1'b0; step(2);
    chk_wait("R1 in reset", 1'b0);
    chk("R1 ack in reset", ack_drive, 1'b0);
    rst_n = 1'b1; step(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule